// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus. A 32-bit counter climbs from a reload value, paced by a slow timebase through an optional power-of-two prescaler. When the counter wraps past all-ones, the block raises a reset request for a fixed number of timebase ticks and reloads itself. To keep that from happening, software refreshes the counter by writing a new value to a trigger register. Only a value that differs from the previous one refreshes.

The timer cannot be started or stopped with a single write. Each action needs a specific pair of words written in order to a key register, and any other value cancels a half-finished pair. Register writes are posted. The slow-domain state changes only on a timebase tick, and each posted register has its own busy flag in a status register. The flag stays set until that tick arrives. In the bus clock domain the timebase is an enable pulse, `tick_i`.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter is stopped, COUNT (address 2) and LOAD (address 3) both read 0xFFFFFFFF minus TIMEOUT, CTRL (address 1) and PEND (address 6) read 0, and `wdt_reset_o` is low. Timebase ticks do not move the counter.
- R2: Address 0 reads the REV_CODE parameter in bits 7:0, with zeros above.
- R3: A write to CTRL, LOAD, TRIG (address 4) or KEY (address 5) sets PEND bit 0, 2, 3 or 4 respectively. The bit stays set across bus cycles until the next tick after the write, and that tick applies the value and clears the bit.
- R4: An applied 0x0000BBBB followed directly by an applied 0x00004444 on KEY starts the counter. Counting begins on the tick after the second word.
- R5: An applied 0x0000AAAA followed directly by an applied 0x00005555 on KEY stops the counter. The tick that applies the second word still counts.
- R6: A second key word without its matching first word directly before it has no effect, and any other key value clears a pending first word.
- R7: An applied TRIG value reloads the counter from LOAD only when it differs from the previous TRIG value, which is 0 after reset. A reload wins over counting on the same tick, and TRIG reads back the last applied value.
- R8: CTRL bit 5 enables the prescaler and bits 4:2 hold the ratio N. When the prescaler is enabled the running counter advances once every 2^N ticks, and when it is disabled it advances on every tick. A new CTRL value governs ticks after the one that applies it, and the counter never changes between ticks.
- R9: A step from 0xFFFFFFFF reloads the counter from LOAD and holds `wdt_reset_o` high for RST_TICKS ticks.
- R10: COUNT, REV and PEND are read-only, so writes to them change nothing. `bus_rdata_o` is 0 when `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the strobe |
| wdt_reset_o | output | 1 | Reset request |

## Verification
On every cycle the assertions check four things. The counter holds between ticks. Each start or stop of counting is traced back to an applied second key word. A reset pulse rises only right after the counter was all-ones and does not drop between ticks. A write to LOAD raises its pending flag. The bench scenarios cover the rest: exact counter values under each prescaler ratio, the rejection of broken and interleaved key pairs, the rule that an equal trigger value is ignored, and the full width of the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int A_REV   = 0;
    localparam int A_CTRL  = 1;
    localparam int A_COUNT = 2;
    localparam int A_LOAD  = 3;
    localparam int A_TRIG  = 4;
    localparam int A_KEY   = 5;
    localparam int A_PEND  = 6;

    localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
    localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
    localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
    localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_RUN,
        KS_ARM_HALT
    } key_state_e;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int W = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_i,
    output logic         pend_o,
    output logic [W-1:0] val_o,
    output logic         apply_o
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] val;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i && st_q.pend) st_d.pend = 1'b0;
        if (wr_i) begin
            st_d.pend = 1'b1;
            st_d.val  = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0, val: RST_VAL};
        else        st_q <= st_d;
    end

    assign pend_o  = st_q.pend;
    assign val_o   = st_q.val;
    assign apply_o = tick_i & st_q.pend;
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        apply_i,
    input  logic [31:0] key_i,
    output logic        run_o
);
    typedef struct packed {
        key_state_e ks;
        logic       run;
    } key_t;

    key_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply_i) begin
            st_d.ks = KS_IDLE;
            if (key_i == KEY_RUN_A)
                st_d.ks = KS_ARM_RUN;
            else if (key_i == KEY_HALT_A)
                st_d.ks = KS_ARM_HALT;
            else if (st_q.ks == KS_ARM_RUN && key_i == KEY_RUN_B)
                st_d.run = 1'b1;
            else if (st_q.ks == KS_ARM_HALT && key_i == KEY_HALT_B)
                st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ks: KS_IDLE, run: 1'b0};
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               run_i,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               step_o
);
    localparam int DIV_W = (1 << RATIO_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_t;

    div_t             st_d, st_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] last;

    always_comb begin
        span   = (DIV_W + 1)'(1) << ratio_i;
        last   = DIV_W'(span - (DIV_W + 1)'(1));
        st_d   = st_q;
        step_o = 1'b0;
        if (!run_i) begin
            st_d.div = '0;
        end else if (tick_i) begin
            if (!en_i) begin
                step_o = 1'b1;
            end else if (st_q.div == last) begin
                st_d.div = '0;
                step_o   = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int          ADDR_W    = 3,
    parameter int          RATIO_W   = 3,
    parameter logic [31:0] TIMEOUT   = 32'd1000,
    parameter int          RST_TICKS = 4,
    parameter logic [7:0]  REV_CODE  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              wdt_reset_o
);
    localparam logic [31:0] DEF_LOAD = 32'hFFFF_FFFF - TIMEOUT;
    localparam int          RC_W     = $clog2(RST_TICKS + 1);
    localparam int          CTL_W    = RATIO_W + 1;

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] ratio;
        logic [31:0]        load;
        logic [31:0]        count;
        logic [31:0]        trig_last;
        logic [RC_W-1:0]    rcnt;
    } core_t;

    core_t st_d, st_q;

    logic             wr_ctrl, wr_load, wr_trig, wr_key;
    logic             pd_ctrl, pd_load, pd_trig, pd_key;
    logic             ap_ctrl, ap_load, ap_trig, key_apply;
    logic [CTL_W-1:0] ctrl_val;
    logic [31:0]      load_val, trig_val, key_val;
    logic             run, step;
    logic [31:0]      load_eff, cnt_now;
    logic [4:0]       pend;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(A_CTRL));
    assign wr_load = bus_wr_i && (bus_addr_i == ADDR_W'(A_LOAD));
    assign wr_trig = bus_wr_i && (bus_addr_i == ADDR_W'(A_TRIG));
    assign wr_key  = bus_wr_i && (bus_addr_i == ADDR_W'(A_KEY));

    wdt_post_slot #(.W(CTL_W), .RST_VAL('0)) u_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
        .wdata_i(bus_wdata_i[RATIO_W+2:2]), .tick_i(tick_i),
        .pend_o(pd_ctrl), .val_o(ctrl_val), .apply_o(ap_ctrl));

    wdt_post_slot #(.W(32), .RST_VAL(DEF_LOAD)) u_slot_load (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_load),
        .wdata_i(bus_wdata_i), .tick_i(tick_i),
        .pend_o(pd_load), .val_o(load_val), .apply_o(ap_load));

    wdt_post_slot #(.W(32), .RST_VAL('0)) u_slot_trig (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_trig),
        .wdata_i(bus_wdata_i), .tick_i(tick_i),
        .pend_o(pd_trig), .val_o(trig_val), .apply_o(ap_trig));

    wdt_post_slot #(.W(32), .RST_VAL('0)) u_slot_key (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_key),
        .wdata_i(bus_wdata_i), .tick_i(tick_i),
        .pend_o(pd_key), .val_o(key_val), .apply_o(key_apply));

    wdt_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .apply_i(key_apply),
        .key_i(key_val), .run_o(run));

    wdt_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
        .en_i(st_q.en), .ratio_i(st_q.ratio), .step_o(step));

    // Bit positions of the status word are part of the programming model.
    assign pend = {pd_key, pd_trig, pd_load, 1'b0, pd_ctrl};

    always_comb begin
        st_d     = st_q;
        load_eff = ap_load ? load_val : st_q.load;
        if (ap_ctrl) begin
            st_d.en    = ctrl_val[RATIO_W];
            st_d.ratio = ctrl_val[RATIO_W-1:0];
        end
        if (ap_load) st_d.load = load_val;
        if (tick_i && st_q.rcnt != '0) st_d.rcnt = st_q.rcnt - 1'b1;
        if (ap_trig) st_d.trig_last = trig_val;
        if (ap_trig && trig_val != st_q.trig_last) begin
            st_d.count = load_eff;
        end else if (step) begin
            if (st_q.count == 32'hFFFF_FFFF) begin
                st_d.count = load_eff;
                st_d.rcnt  = RC_W'(RST_TICKS);
            end else begin
                st_d.count = st_q.count + 32'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, ratio: '0, load: DEF_LOAD, count: DEF_LOAD,
                      trig_last: '0, rcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_now     = st_q.count;
    assign wdt_reset_o = (st_q.rcnt != '0);

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (int'(bus_addr_i))
                A_REV:   bus_rdata_o = {24'd0, REV_CODE};
                A_CTRL:  bus_rdata_o = 32'({st_q.en, st_q.ratio, 2'b00});
                A_COUNT: bus_rdata_o = st_q.count;
                A_LOAD:  bus_rdata_o = st_q.load;
                A_TRIG:  bus_rdata_o = st_q.trig_last;
                A_PEND:  bus_rdata_o = {27'd0, pend};
                default: bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              wdt_reset_o,
    input logic [31:0]       cnt_now,
    input logic              run,
    input logic              key_apply,
    input logic [31:0]       key_val,
    input logic [4:0]        pend
);
    AST_CNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_now)); // R8

    AST_PEND_AFTER_LOAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_W'(A_LOAD)) |=> pend[2]); // R3

    AST_RUN_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(key_apply && key_val == KEY_RUN_B)); // R4

    AST_HALT_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(key_apply && key_val == KEY_HALT_B)); // R5

    AST_RST_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset_o) |-> $past(cnt_now) == 32'hFFFF_FFFF); // R9

    AST_RST_HELD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset_o && !tick_i) |=> wdt_reset_o); // R9
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .wdt_reset_o(wdt_reset_o), .cnt_now(cnt_now),
    .run(run), .key_apply(key_apply), .key_val(key_val), .pend(pend));

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 80;
    localparam logic [3:0] WR = 4'd0, RD = 4'd1, TK = 4'd2, RS = 4'd3;

    // {op, addr, requirement, data, expected}
    localparam logic [79:0] VEC [NV] = '{
        {RD, 4'd0, 8'd2,  32'h0, 32'h5A},          // R2 revision
        {RD, 4'd6, 8'd1,  32'h0, 32'h0},           // R1 pend clear
        {RD, 4'd2, 8'd1,  32'h0, 32'hFFFFFC17},    // R1 count default
        {RD, 4'd3, 8'd1,  32'h0, 32'hFFFFFC17},    // R1 load default
        {RD, 4'd1, 8'd1,  32'h0, 32'h0},           // R1 ctrl
        {RS, 4'd0, 8'd1,  32'h0, 32'h0},           // R1 reset low
        {TK, 4'd0, 8'd1,  32'd3, 32'h0},
        {RD, 4'd2, 8'd1,  32'h0, 32'hFFFFFC17},    // R1 stopped
        {WR, 4'd2, 8'd10, 32'h0, 32'h0},           // R10 write count
        {TK, 4'd0, 8'd10, 32'd1, 32'h0},
        {RD, 4'd2, 8'd10, 32'h0, 32'hFFFFFC17},    // R10 ignored
        {WR, 4'd3, 8'd3,  32'hFFFFFFF0, 32'h0},
        {RD, 4'd6, 8'd3,  32'h0, 32'h4},           // R3 load pend bit 2
        {TK, 4'd0, 8'd3,  32'd1, 32'h0},
        {RD, 4'd6, 8'd3,  32'h0, 32'h0},
        {RD, 4'd3, 8'd3,  32'h0, 32'hFFFFFFF0},
        {WR, 4'd4, 8'd3,  32'h1, 32'h0},
        {RD, 4'd6, 8'd3,  32'h0, 32'h8},           // R3 trig pend bit 3
        {TK, 4'd0, 8'd7,  32'd1, 32'h0},
        {RD, 4'd2, 8'd7,  32'h0, 32'hFFFFFFF0},    // R7 reload
        {WR, 4'd5, 8'd6,  32'h4444, 32'h0},        // R6 lone second word
        {TK, 4'd0, 8'd6,  32'd2, 32'h0},
        {RD, 4'd2, 8'd6,  32'h0, 32'hFFFFFFF0},
        {WR, 4'd5, 8'd3,  32'hBBBB, 32'h0},
        {RD, 4'd6, 8'd3,  32'h0, 32'h10},          // R3 key pend bit 4
        {TK, 4'd0, 8'd6,  32'd1, 32'h0},
        {WR, 4'd5, 8'd6,  32'hAAAA, 32'h0},        // R6 interleaved
        {TK, 4'd0, 8'd6,  32'd1, 32'h0},
        {WR, 4'd5, 8'd6,  32'h4444, 32'h0},
        {TK, 4'd0, 8'd6,  32'd2, 32'h0},
        {RD, 4'd2, 8'd6,  32'h0, 32'hFFFFFFF0},
        {WR, 4'd5, 8'd4,  32'hBBBB, 32'h0},        // R4 start
        {TK, 4'd0, 8'd4,  32'd1, 32'h0},
        {WR, 4'd5, 8'd4,  32'h4444, 32'h0},
        {TK, 4'd0, 8'd4,  32'd1, 32'h0},
        {RD, 4'd2, 8'd4,  32'h0, 32'hFFFFFFF0},
        {TK, 4'd0, 8'd4,  32'd2, 32'h0},
        {RD, 4'd2, 8'd4,  32'h0, 32'hFFFFFFF2},
        {WR, 4'd5, 8'd6,  32'hAAAA, 32'h0},        // R6 broken stop
        {TK, 4'd0, 8'd6,  32'd1, 32'h0},
        {WR, 4'd5, 8'd6,  32'h1234, 32'h0},
        {TK, 4'd0, 8'd6,  32'd1, 32'h0},
        {WR, 4'd5, 8'd6,  32'h5555, 32'h0},
        {TK, 4'd0, 8'd6,  32'd1, 32'h0},
        {RD, 4'd2, 8'd6,  32'h0, 32'hFFFFFFF5},
        {WR, 4'd4, 8'd7,  32'h1, 32'h0},           // R7 same value
        {TK, 4'd0, 8'd7,  32'd1, 32'h0},
        {RD, 4'd2, 8'd7,  32'h0, 32'hFFFFFFF6},
        {WR, 4'd4, 8'd7,  32'h2, 32'h0},           // R7 new value
        {TK, 4'd0, 8'd7,  32'd1, 32'h0},
        {RD, 4'd2, 8'd7,  32'h0, 32'hFFFFFFF0},
        {RD, 4'd4, 8'd7,  32'h0, 32'h2},
        {WR, 4'd1, 8'd8,  32'h28, 32'h0},          // R8 enable, ratio 2
        {TK, 4'd0, 8'd8,  32'd1, 32'h0},
        {RD, 4'd2, 8'd8,  32'h0, 32'hFFFFFFF1},
        {RD, 4'd1, 8'd8,  32'h0, 32'h28},
        {TK, 4'd0, 8'd8,  32'd3, 32'h0},
        {RD, 4'd2, 8'd8,  32'h0, 32'hFFFFFFF1},
        {TK, 4'd0, 8'd8,  32'd1, 32'h0},
        {RD, 4'd2, 8'd8,  32'h0, 32'hFFFFFFF2},
        {WR, 4'd1, 8'd8,  32'h0, 32'h0},           // R8 disable
        {TK, 4'd0, 8'd8,  32'd1, 32'h0},
        {RD, 4'd2, 8'd8,  32'h0, 32'hFFFFFFF2},
        {TK, 4'd0, 8'd9,  32'd13, 32'h0},
        {RD, 4'd2, 8'd9,  32'h0, 32'hFFFFFFFF},    // R9 at top
        {RS, 4'd0, 8'd9,  32'h0, 32'h0},
        {TK, 4'd0, 8'd9,  32'd1, 32'h0},
        {RD, 4'd2, 8'd9,  32'h0, 32'hFFFFFFF0},    // R9 wrap reload
        {RS, 4'd0, 8'd9,  32'h0, 32'h1},
        {TK, 4'd0, 8'd9,  32'd3, 32'h0},
        {RS, 4'd0, 8'd9,  32'h0, 32'h1},
        {TK, 4'd0, 8'd9,  32'd1, 32'h0},
        {RS, 4'd0, 8'd9,  32'h0, 32'h0},           // R9 pulse ended
        {RD, 4'd2, 8'd9,  32'h0, 32'hFFFFFFF4},
        {WR, 4'd5, 8'd5,  32'hAAAA, 32'h0},        // R5 stop
        {TK, 4'd0, 8'd5,  32'd1, 32'h0},
        {WR, 4'd5, 8'd5,  32'h5555, 32'h0},
        {TK, 4'd0, 8'd5,  32'd1, 32'h0},
        {TK, 4'd0, 8'd5,  32'd3, 32'h0},
        {RD, 4'd2, 8'd5,  32'h0, 32'hFFFFFFF6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        wdt_reset_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
        .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .wdt_reset_o(wdt_reset_o));

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        #1 d = bus_rdata_o;
        bus_rd_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before R1..R10 sequence ended");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op;
            logic [2:0]  a;
            int          rq;
            logic [31:0] d, e;
            op = VEC[i][79:76];
            a  = VEC[i][74:72];
            rq = int'(VEC[i][71:64]);
            d  = VEC[i][63:32];
            e  = VEC[i][31:0];
            case (op)
                WR: bus_wr(a, d);
                TK: ticks(int'(d));
                RD: begin bus_rd(a, rv); check(rq, rv, e); end
                default: begin @(negedge clk); check(rq, 32'(wdt_reset_o), e); end
            endcase
        end

        // R3: a posted write stays pending across idle bus cycles
        bus_wr(3'd1, 32'h20);
        repeat (10) @(negedge clk);
        bus_rd(3'd6, rv); check(3, rv, 32'h1);
        ticks(1);
        bus_rd(3'd6, rv); check(3, rv, 32'h0);
        bus_rd(3'd1, rv); check(8, rv, 32'h20);

        // R10: rdata is zero without a read strobe
        @(negedge clk); bus_addr_i = 3'd0; #1 check(10, bus_rdata_o, 32'h0);

        // R1: reset while running restores defaults and stops the counter
        bus_wr(3'd5, 32'hBBBB); ticks(1);
        bus_wr(3'd5, 32'h4444); ticks(3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(3'd2, rv); check(1, rv, 32'hFFFFFC17);
        bus_rd(3'd1, rv); check(1, rv, 32'h0);
        ticks(4);
        bus_rd(3'd2, rv); check(1, rv, 32'hFFFFFC17);
        @(negedge clk); check(1, 32'(wdt_reset_o), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule